// File: doc/BRIEF.md
# Store-and-Forward Packet Stream FIFO

This block is a byte-wide streaming FIFO that holds each packet back until the whole packet is inside. Beats enter on a ready/valid input port with an end-of-packet flag. They are written into a fixed-depth circular store, and the end-of-packet flag is stored with each byte. The output port stays silent until the oldest stored packet is complete. Once it is, the output port releases that packet beat by beat under ordinary ready/valid flow control.

The input side is not held back by the packet gating. It keeps taking beats while earlier complete packets wait in the queue, so several packets can sit in the store at once. The only input backpressure comes from a full store. A packet longer than the whole store can therefore never complete, and it stalls both sides for good.

The output side is one small state machine:
- **OUT_WAIT** drives output valid low.
- **OUT_SEND** drives output valid high.

It moves between these states on three named transitions:
- **T_RELEASE** (OUT_WAIT to OUT_SEND) fires on the first clock edge at which the completed-packet count is non-zero.
- **T_CHAIN** (OUT_SEND to OUT_SEND) fires when a final beat is taken while the updated count is still non-zero.
- **T_DONE** (OUT_SEND to OUT_WAIT) fires when a final beat is taken and the updated count reaches zero.

The completed-packet count rises when a beat with its end flag set is written. It falls when such a beat is read. It is unchanged when both happen in the same cycle.

Top module: `pkt_sf_fifo`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1, `is_empty` is 1 and `is_full` is 0.
- R2: While no complete packet is stored, `out_valid` stays 0 even if beats without the end flag are stored, and `in_ready` stays 1 as long as the store has room.
- R3: When no packet is stored and a beat with `in_last`=1 is accepted at clock edge E, `out_valid` is still 0 after E and is 1 after edge E+1.
- R4: Beats leave in the order they were accepted. Each output beat carries its byte on `out_data` and its stored end flag on `out_last`, so that `out_last`=1 appears exactly on the final beat of each packet.
- R5: When more complete packets are queued behind the head packet, `out_valid` stays 1 across the packet boundary, and the first beat of the next packet is presented in the cycle right after the final beat of the current one.
- R6: With DEPTH beats stored, `is_full` is 1 and `in_ready` is 0. A beat offered in that state is not stored.
- R7: `is_empty` is 1 exactly when no beat is stored.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data` and `out_last` hold their values into the next cycle.
- R9: If a final beat is read in the same cycle as another packet's final beat is written, the packet count is unchanged and `out_valid` stays 1 in the next cycle, presenting the next packet's first beat.
- R10: When the final beat of the only complete packet is read, `out_valid` is 0 in the next cycle, even if beats of an unfinished packet remain stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_data | input | DATA_W | Input byte |
| in_valid | input | 1 | Input beat offered |
| in_last | input | 1 | Input beat ends its packet |
| in_ready | output | 1 | Store can take a beat |
| out_data | output | DATA_W | Output byte |
| out_valid | output | 1 | Output beat offered (complete packet at head) |
| out_last | output | 1 | Output beat ends its packet |
| out_ready | input | 1 | Downstream takes the beat |
| is_full | output | 1 | DEPTH beats stored |
| is_empty | output | 1 | No beat stored |

## Verification
The two functions that can coincide are the count increment from a final-beat write and the count decrement from a final-beat read. The bench first queues a two-beat packet and starts a second packet. It then drives the input with the second packet's final beat in the same cycle that the output reads the first packet's final beat. The cycle after that must still show valid output carrying the second packet's first byte, and a separate case shows valid dropping when no write coincides with the read. Sweeps over every packet length from one to DEPTH, with steady and toggling output ready, compare each beat against a queue the bench builds from accepted inputs.

// File: rtl/pkt_sf_fifo_pkg.sv
package pkt_sf_fifo_pkg;

    typedef enum logic [0:0] {
        OUT_WAIT = 1'b0,
        OUT_SEND = 1'b1
    } out_state_e;

endpackage

// File: rtl/pkf_store.sv
module pkf_store #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_last,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_last,
    output logic              full,
    output logic              empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int EW = DATA_W + 1;

    logic [EW-1:0] mem [DEPTH];
    logic [AW:0]   wr_ptr;
    logic [AW:0]   rd_ptr;

    // wrap bit differs and index bits match: the store is full
    assign full  = (wr_ptr[AW] != rd_ptr[AW]) && (wr_ptr[AW-1:0] == rd_ptr[AW-1:0]);
    assign empty = (wr_ptr == rd_ptr);

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_ptr[AW-1:0]] <= {wr_last, wr_data};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (wr_en) wr_ptr <= wr_ptr + 1'b1;
            if (rd_en) rd_ptr <= rd_ptr + 1'b1;
        end
    end

    assign rd_last = mem[rd_ptr[AW-1:0]][EW-1];
    assign rd_data = mem[rd_ptr[AW-1:0]][DATA_W-1:0];

endmodule

// File: rtl/pkf_pkt_count.sv
module pkf_pkt_count #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    input  logic          dec,
    output logic [CW-1:0] cnt_q,
    output logic [CW-1:0] cnt_d
);
    always_comb begin
        unique case ({inc, dec})
            2'b10:   cnt_d = cnt_q + 1'b1;
            2'b01:   cnt_d = cnt_q - 1'b1;
            default: cnt_d = cnt_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/pkf_out_ctrl.sv
module pkf_out_ctrl
    import pkt_sf_fifo_pkg::*;
#(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] pkt_cnt,
    input  logic [CW-1:0] pkt_cnt_next,
    input  logic          head_last,
    input  logic          take,
    output logic          send
);
    out_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= OUT_WAIT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OUT_WAIT: begin
                if (pkt_cnt != '0) state_d = OUT_SEND;          // T_RELEASE
            end
            OUT_SEND: begin
                if (take && head_last) begin
                    if (pkt_cnt_next == '0) state_d = OUT_WAIT; // T_DONE
                    else                    state_d = OUT_SEND; // T_CHAIN
                end
            end
            default: state_d = OUT_WAIT;
        endcase
    end

    always_comb begin
        unique case (state_q)
            OUT_SEND: send = 1'b1;
            default:  send = 1'b0;
        endcase
    end

endmodule

// File: rtl/pkt_sf_fifo.sv
module pkt_sf_fifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    input  logic              in_last,
    output logic              in_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_valid,
    output logic              out_last,
    input  logic              out_ready,
    output logic              is_full,
    output logic              is_empty
);
    localparam int CW = $clog2(DEPTH) + 1;

    logic          wr_en, rd_en;
    logic          st_full, st_empty;
    logic [CW-1:0] cnt_q, cnt_d;

    assign in_ready  = !st_full;
    assign wr_en     = in_valid && in_ready;
    assign rd_en     = out_valid && out_ready;
    assign is_full   = st_full;
    assign is_empty  = st_empty;

    pkf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (in_data),
        .wr_last (in_last),
        .rd_en   (rd_en),
        .rd_data (out_data),
        .rd_last (out_last),
        .full    (st_full),
        .empty   (st_empty)
    );

    pkf_pkt_count #(.CW(CW)) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (wr_en && in_last),
        .dec   (rd_en && out_last),
        .cnt_q (cnt_q),
        .cnt_d (cnt_d)
    );

    pkf_out_ctrl #(.CW(CW)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .pkt_cnt      (cnt_q),
        .pkt_cnt_next (cnt_d),
        .head_last    (out_last),
        .take         (rd_en),
        .send         (out_valid)
    );

endmodule

// File: rtl/pkt_sf_fifo_chk.sv
module pkt_sf_fifo_chk #(
    parameter int DEPTH = 8
) (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic in_last,
    input logic in_ready,
    input logic out_valid,
    input logic out_last,
    input logic out_ready,
    input logic is_full,
    input logic is_empty
);
    localparam int CW = $clog2(DEPTH) + 1;

    logic [CW-1:0] beats, pkts;
    logic wr, rd, wr_end, rd_end;

    assign wr     = in_valid && in_ready;
    assign rd     = out_valid && out_ready;
    assign wr_end = wr && in_last;
    assign rd_end = rd && out_last;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beats <= '0;
            pkts  <= '0;
        end else begin
            beats <= beats + CW'(wr) - CW'(rd);
            pkts  <= pkts + CW'(wr_end) - CW'(rd_end);
        end
    end

    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (beats == CW'(DEPTH)) |-> (!in_ready && is_full));
    p_empty_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        is_empty == (beats == '0));
    p_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (pkts != '0));
    p_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pkts == '0 && wr_end) |-> ##2 out_valid);
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_last)));
    p_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_end && pkts == CW'(1) && !wr_end) |=> !out_valid);

endmodule

bind pkt_sf_fifo pkt_sf_fifo_chk #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_last   (in_last),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_last  (out_last),
    .out_ready (out_ready),
    .is_full   (is_full),
    .is_empty  (is_empty)
);

// File: tb/test_pkt_sf_fifo.sv
module test_pkt_sf_fifo;
    localparam int DW = 8;
    localparam int DEPTH = 8;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic in_valid = 1'b0, in_last = 1'b0, out_ready = 1'b0;
    logic in_ready, out_valid, out_last, is_full, is_empty;
    logic [DW-1:0] out_data;

    pkt_sf_fifo #(.DATA_W(DW), .DEPTH(DEPTH)) i_pkt_sf_fifo (
        .clk(clk), .rst_n(rst_n),
        .in_data(in_data), .in_valid(in_valid), .in_last(in_last), .in_ready(in_ready),
        .out_data(out_data), .out_valid(out_valid), .out_last(out_last), .out_ready(out_ready),
        .is_full(is_full), .is_empty(is_empty)
    );

    int checks = 0;
    int fails = 0;
    logic [DW:0] exp_q[$];
    logic s_mv, s_ml, s_sr, s_full, s_empty;
    logic [DW-1:0] s_md;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one cycle: drive at negedge, sample, then account for handshakes at posedge
    task automatic step(input logic sv, input logic [DW-1:0] sd, input logic sl, input logic mr);
        logic [DW:0] e;
        @(negedge clk);
        in_valid = sv; in_data = sd; in_last = sl; out_ready = mr;
        #1;
        s_mv = out_valid; s_ml = out_last; s_md = out_data;
        s_sr = in_ready; s_full = is_full; s_empty = is_empty;
        @(posedge clk);
        if (sv && s_sr) exp_q.push_back({sl, sd});
        if (s_mv && mr) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R4 beat with nothing queued", {s_ml, s_md}, 0);
            end else begin
                e = exp_q.pop_front();
                chk({s_ml, s_md} == e, "R4 order/last", {s_ml, s_md}, e);
            end
        end
    endtask

    task automatic idle();
        step(1'b0, '0, 1'b0, 1'b0);
    endtask

    task automatic send_pkt(input int len, input logic [DW-1:0] base);
        int i = 0;
        while (i < len) begin
            step(1'b1, base + DW'(i), (i == len - 1), 1'b0);
            if (s_sr) i++;
        end
    endtask

    task automatic wait_valid();
        for (int k = 0; k < 10; k++) begin
            idle();
            if (s_mv) break;
        end
    endtask

    task automatic drain(input bit toggle);
        int n = 0;
        while (exp_q.size() != 0 && n < 200) begin
            step(1'b0, '0, 1'b0, toggle ? logic'(n % 2) : 1'b1);
            n++;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL R4 watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1 / R7: reset state
        idle();
        chk(s_mv == 0, "R1 out_valid", s_mv, 0);
        chk(s_sr == 1, "R1 in_ready", s_sr, 1);
        chk(s_empty == 1, "R1 R7 is_empty", s_empty, 1);
        chk(s_full == 0, "R1 is_full", s_full, 0);

        // R2: partial packet is held back
        for (int i = 0; i < 3; i++) step(1'b1, 8'h10 + DW'(i), 1'b0, 1'b1);
        for (int i = 0; i < 3; i++) begin
            idle();
            chk(s_mv == 0, "R2 valid low on partial", s_mv, 0);
            chk(s_sr == 1, "R2 input still ready", s_sr, 1);
        end
        chk(s_empty == 0, "R7 not empty with partial", s_empty, 0);

        // R3: release two edges after the end beat
        step(1'b1, 8'h13, 1'b1, 1'b0);
        idle();
        chk(s_mv == 0, "R3 valid after E", s_mv, 0);
        idle();
        chk(s_mv == 1, "R3 valid after E+1", s_mv, 1);

        // R8: hold while stalled
        begin
            logic [DW-1:0] d0;
            d0 = s_md;
            for (int i = 0; i < 3; i++) begin
                idle();
                chk(s_mv == 1 && s_md == d0 && s_ml == 0, "R8 hold", {s_mv, s_md}, {1'b1, d0});
            end
        end
        drain(1'b0);
        idle();
        chk(s_mv == 0, "R10 valid drops", s_mv, 0);
        chk(s_empty == 1, "R7 empty after drain", s_empty, 1);

        // sweep: every length, steady and toggling ready (R4)
        for (int len = 1; len <= DEPTH; len++) begin
            for (int mode = 0; mode < 2; mode++) begin
                send_pkt(len, DW'(len * 16 + mode * 8) ^ 8'h5A);
                wait_valid();
                chk(s_mv == 1, "R3 sweep release", s_mv, 1);
                drain(mode == 1);
                idle();
                chk(s_mv == 0 && s_empty == 1, "R7 R10 sweep end", {s_mv, s_empty}, 2'b01);
            end
        end

        // R6: full store refuses beats
        send_pkt(DEPTH, 8'hA0);
        idle();
        chk(s_full == 1, "R6 is_full", s_full, 1);
        chk(s_sr == 0, "R6 in_ready low", s_sr, 0);
        for (int i = 0; i < 3; i++) step(1'b1, 8'hEE, 1'b1, 1'b0);
        drain(1'b0);
        idle();
        chk(s_mv == 0 && s_empty == 1, "R6 offered beat not stored", {s_mv, s_empty}, 2'b01);

        // R5: queued packets flow without gaps
        send_pkt(2, 8'h20);
        send_pkt(3, 8'h30);
        send_pkt(1, 8'h40);
        wait_valid();
        for (int i = 0; i < 6; i++) begin
            step(1'b0, '0, 1'b0, 1'b1);
            chk(s_mv == 1, "R5 valid across boundary", s_mv, 1);
        end
        idle();
        chk(s_mv == 0, "R5 R10 after last packet", s_mv, 0);

        // R10: drops with an unfinished packet stored
        send_pkt(2, 8'h50);
        step(1'b1, 8'h60, 1'b0, 1'b0);
        wait_valid();
        step(1'b0, '0, 1'b0, 1'b1);
        step(1'b0, '0, 1'b0, 1'b1);
        idle();
        chk(s_mv == 0, "R10 valid low with partial left", s_mv, 0);
        chk(s_empty == 0, "R7 partial remains", s_empty, 0);
        step(1'b1, 8'h61, 1'b1, 1'b0);
        wait_valid();
        drain(1'b0);

        // R9: simultaneous end-beat write and read
        send_pkt(2, 8'h70);
        wait_valid();
        step(1'b1, 8'h80, 1'b0, 1'b1);
        step(1'b1, 8'h81, 1'b1, 1'b1);
        idle();
        chk(s_mv == 1, "R9 valid kept", s_mv, 1);
        chk(s_md == 8'h80, "R9 next head byte", s_md, 8'h80);
        drain(1'b0);
        idle();
        chk(s_mv == 0 && s_empty == 1, "R9 end state", {s_mv, s_empty}, 2'b01);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule